// File: doc/BRIEF.md
# Frequent Pattern Line Compressor

This block shrinks one 64-byte memory line before it is written to a wear-sensitive memory. The line is treated as sixteen 32-bit words. Word 0 occupies `line_data[31:0]` and word *i* occupies `line_data[32*i+31 : 32*i]`. Each word is matched against eight fixed patterns. For each word the block emits a 3-bit pattern code, followed by only the bits needed to rebuild the word. Words are handled one per clock. The finished bitstream is presented with its length in bits.

A matching unpacker sits in the same top. It takes a packed stream and rebuilds the sixteen words, again at one word per clock, so that a round trip can be checked.

Both data paths use valid/ready handshakes. A transfer takes place on a rising clock edge where valid and ready are both high. An input ready is high only while its path is idle. Once an output valid rises, it stays high, and the data and size stay unchanged, until the matching ready is sampled high. A valid offered while the path is busy is not taken. `pack_done` is a plain one-cycle status pulse.

Top module: `fpc_line_codec`

## Requirements
- R1: An all-zero word gets code 000 and adds no payload bits.
- R2: A word equal to the sign extension of its low 4 bits gets code 001 and a 4-bit payload holding bits 3..0.
- R3: A word equal to the sign extension of its low byte gets code 010 and an 8-bit payload holding bits 7..0.
- R4: A word equal to the sign extension of its low 16 bits gets code 011 and a 16-bit payload holding bits 15..0.
- R5: A word whose bits 15..0 are zero gets code 100 and a 16-bit payload holding bits 31..16.
- R6: A word whose upper half is the sign extension of bits 23..16 and whose lower half is the sign extension of bits 7..0 gets code 101. Its 16-bit payload is bits 23..16 followed by bits 7..0.
- R7: A word of four equal bytes gets code 110 with an 8-bit payload holding bits 7..0. Every other word gets code 111 with all 32 bits.
- R8: When several patterns match, the pattern with the fewest payload bits wins. On a tie, the lower code wins. For example, 0xFFFFFFFF gets code 001 and 0x00010000 gets code 100.
- R9: Fields are packed from stream position 0 upward, starting with word 0. Stream position p is `pack_bits[559-p]`. Each word contributes its code MSB first, then its payload MSB first. All bits past the end of the stream are zero.
- R10: `pack_size` equals 48 plus the sum of all payload lengths, so it lies between 48 and 560.
- R11: `pack_valid` rises and `pack_done` pulses for exactly one cycle, 16 clock edges after the edge that accepts the line. The result then holds with `line_ready` low, and a line offered meanwhile is ignored, until `pack_ready` is sampled high.
- R12: Given a packed stream, the unpacker presents exactly the original line on `rebuilt_line`. `rebuilt_valid` rises 16 edges after the accepting edge and holds until `rebuilt_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_valid | input | 1 | Line offered for packing |
| line_ready | output | 1 | Packer idle and able to take a line |
| line_data | input | 512 | Sixteen words, word 0 in the low bits |
| pack_valid | output | 1 | Packed result available |
| pack_ready | input | 1 | Consumer takes the packed result |
| pack_bits | output | 560 | Packed stream, position 0 at bit 559 |
| pack_size | output | 10 | Stream length in bits |
| pack_done | output | 1 | One-cycle pulse when a result first appears |
| unpk_valid | input | 1 | Packed stream offered for unpacking |
| unpk_ready | output | 1 | Unpacker idle |
| unpk_bits | input | 560 | Packed stream to rebuild |
| rebuilt_valid | output | 1 | Rebuilt line available |
| rebuilt_ready | input | 1 | Consumer takes the rebuilt line |
| rebuilt_line | output | 512 | Rebuilt line |

## Verification
Each path spends one edge accepting its input and then one edge per word. Its result is therefore due just after the 16th edge following the acceptance. The bench drives and samples on falling edges and counts exactly sixteen of them after the accepting edge. It flags any `pack_done` or `pack_valid` seen earlier, and it checks that `pack_done` has dropped one cycle later. The packed bits, size and per-word codes are compared at that same sample point. The rebuilt line is compared at the same offset after the unpacker accepts. The held state is checked just before each ready is released.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int WORD_W  = 32;
  localparam int CODE_W  = 3;
  localparam int FIELD_W = CODE_W + WORD_W;
  localparam int LEN_W   = 6;

  typedef enum logic [CODE_W-1:0] {
    C_ZERO = 3'b000,
    C_NIB  = 3'b001,
    C_BYTE = 3'b010,
    C_HALF = 3'b011,
    C_HIGH = 3'b100,
    C_PAIR = 3'b101,
    C_REP  = 3'b110,
    C_RAW  = 3'b111
  } code_e;

  function automatic logic [LEN_W-1:0] payload_len(code_e c);
    case (c)
      C_ZERO:                 payload_len = 6'd0;
      C_NIB:                  payload_len = 6'd4;
      C_BYTE, C_REP:          payload_len = 6'd8;
      C_HALF, C_HIGH, C_PAIR: payload_len = 6'd16;
      default:                payload_len = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/fpc_word_classify.sv
module fpc_word_classify
  import fpc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output code_e             code,
  output logic [LEN_W-1:0]  len,
  output logic [WORD_W-1:0] pay_left
);
  localparam int NSX = 3;
  localparam int SX_W [NSX] = '{4, 8, 16};

  logic [NSX-1:0] sx_ok;
  logic [1:0]     half_ok;
  logic           rep_ok;
  logic [WORD_W-1:0] pay_right;

  // word equal to the sign extension of its low SX_W[g] bits
  for (genvar g = 0; g < NSX; g++) begin : g_sx
    assign sx_ok[g] = (word[WORD_W-1:SX_W[g]-1] == '0) ||
                      (word[WORD_W-1:SX_W[g]-1] == '1);
  end

  // each half equal to the sign extension of its low byte
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_ok[h] = (word[16*h+15:16*h+7] == '0) ||
                        (word[16*h+15:16*h+7] == '1);
  end

  assign rep_ok = (word[31:24] == word[23:16]) &&
                  (word[23:16] == word[15:8])  &&
                  (word[15:8]  == word[7:0]);

  // ordered by payload size, then by code value
  always_comb begin
    if (word == '0)            code = C_ZERO;
    else if (sx_ok[0])         code = C_NIB;
    else if (sx_ok[1])         code = C_BYTE;
    else if (rep_ok)           code = C_REP;
    else if (sx_ok[2])         code = C_HALF;
    else if (word[15:0] == '0) code = C_HIGH;
    else if (&half_ok)         code = C_PAIR;
    else                       code = C_RAW;
  end

  always_comb begin
    case (code)
      C_ZERO:  pay_right = '0;
      C_NIB:   pay_right = {28'd0, word[3:0]};
      C_BYTE,
      C_REP:   pay_right = {24'd0, word[7:0]};
      C_HALF:  pay_right = {16'd0, word[15:0]};
      C_HIGH:  pay_right = {16'd0, word[31:16]};
      C_PAIR:  pay_right = {16'd0, word[23:16], word[7:0]};
      default: pay_right = word;
    endcase
  end

  assign len      = payload_len(code);
  assign pay_left = pay_right << (LEN_W'(WORD_W) - len);
endmodule

// File: rtl/fpc_word_expand.sv
module fpc_word_expand
  import fpc_pkg::*;
(
  input  code_e             code,
  input  logic [WORD_W-1:0] pay_left,
  output logic [LEN_W-1:0]  len,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] pay;

  assign len = payload_len(code);
  assign pay = pay_left >> (LEN_W'(WORD_W) - len);

  always_comb begin
    case (code)
      C_ZERO:  word = '0;
      C_NIB:   word = {{28{pay[3]}}, pay[3:0]};
      C_BYTE:  word = {{24{pay[7]}}, pay[7:0]};
      C_HALF:  word = {{16{pay[15]}}, pay[15:0]};
      C_HIGH:  word = {pay[15:0], 16'd0};
      C_PAIR:  word = {{8{pay[15]}}, pay[15:8], {8{pay[7]}}, pay[7:0]};
      C_REP:   word = {4{pay[7:0]}};
      default: word = pay;
    endcase
  end
endmodule

// File: rtl/fpc_line_pack.sv
module fpc_line_pack
  import fpc_pkg::*;
#(
  parameter int WORDS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORDS*WORD_W-1:0] in_line,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORDS*FIELD_W-1:0] out_bits,
  output logic [$clog2(WORDS*FIELD_W+1)-1:0] out_size,
  output logic                    out_done
);
  localparam int LINE_W   = WORDS * WORD_W;
  localparam int MAX_BITS = WORDS * FIELD_W;
  localparam int SIZE_W   = $clog2(MAX_BITS + 1);
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int MIN_BITS = WORDS * CODE_W;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} state_e;

  state_e              state;
  logic [LINE_W-1:0]   line_q;
  logic [IDX_W-1:0]    idx;
  logic [SIZE_W-1:0]   off;
  logic [MAX_BITS-1:0] bits_q;
  logic                done_q;

  logic [WORD_W-1:0]   cur_word;
  code_e               cur_code;
  logic [LEN_W-1:0]    cur_len;
  logic [WORD_W-1:0]   cur_pay;
  logic [MAX_BITS-1:0] chunk;

  assign cur_word = line_q[idx*WORD_W +: WORD_W];

  fpc_word_classify u_cls (
    .word     (cur_word),
    .code     (cur_code),
    .len      (cur_len),
    .pay_left (cur_pay)
  );

  assign chunk = {cur_code, cur_pay, {(MAX_BITS-FIELD_W){1'b0}}} >> off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      line_q <= '0;
      idx    <= '0;
      off    <= '0;
      bits_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (in_valid) begin
          line_q <= in_line;
          idx    <= '0;
          off    <= '0;
          bits_q <= '0;
          state  <= S_RUN;
        end
        S_RUN: begin
          bits_q <= bits_q | chunk;
          off    <= off + SIZE_W'(CODE_W) + SIZE_W'(cur_len);
          idx    <= idx + 1'b1;
          if (idx == IDX_W'(WORDS-1)) begin
            state  <= S_HOLD;
            done_q <= 1'b1;
          end
        end
        default: if (out_ready) state <= S_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == S_IDLE);
  assign out_valid = (state == S_HOLD);
  assign out_bits  = bits_q;
  assign out_size  = off;
  assign out_done  = done_q;

  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bits) && $stable(out_size));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  assert_done_on_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_done);

  assert_size_bounds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_size >= SIZE_W'(MIN_BITS)) && (out_size <= SIZE_W'(MAX_BITS)));
endmodule

// File: rtl/fpc_line_unpack.sv
module fpc_line_unpack
  import fpc_pkg::*;
#(
  parameter int WORDS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [WORDS*FIELD_W-1:0] in_bits,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [WORDS*WORD_W-1:0]  out_line
);
  localparam int LINE_W   = WORDS * WORD_W;
  localparam int MAX_BITS = WORDS * FIELD_W;
  localparam int SIZE_W   = $clog2(MAX_BITS + 1);
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1;

  typedef enum logic [1:0] {U_IDLE, U_RUN, U_HOLD} state_e;

  state_e              state;
  logic [MAX_BITS-1:0] bits_q;
  logic [LINE_W-1:0]   line_q;
  logic [IDX_W-1:0]    idx;
  logic [SIZE_W-1:0]   off;

  logic [FIELD_W-1:0]  window;
  logic [LEN_W-1:0]    cur_len;
  logic [WORD_W-1:0]   cur_word;

  assign window = FIELD_W'((bits_q << off) >> (MAX_BITS - FIELD_W));

  fpc_word_expand u_exp (
    .code     (code_e'(window[FIELD_W-1:WORD_W])),
    .pay_left (window[WORD_W-1:0]),
    .len      (cur_len),
    .word     (cur_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= U_IDLE;
      bits_q <= '0;
      line_q <= '0;
      idx    <= '0;
      off    <= '0;
    end else begin
      case (state)
        U_IDLE: if (in_valid) begin
          bits_q <= in_bits;
          line_q <= '0;
          idx    <= '0;
          off    <= '0;
          state  <= U_RUN;
        end
        U_RUN: begin
          line_q[idx*WORD_W +: WORD_W] <= cur_word;
          off   <= off + SIZE_W'(CODE_W) + SIZE_W'(cur_len);
          idx   <= idx + 1'b1;
          if (idx == IDX_W'(WORDS-1)) state <= U_HOLD;
        end
        default: if (out_ready) state <= U_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == U_IDLE);
  assign out_valid = (state == U_HOLD);
  assign out_line  = line_q;

  assert_rebuilt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_line));

  assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(!in_ready));
endmodule

// File: rtl/fpc_line_codec.sv
module fpc_line_codec
  import fpc_pkg::*;
#(
  parameter int WORDS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     line_valid,
  output logic                     line_ready,
  input  logic [WORDS*WORD_W-1:0]  line_data,
  output logic                     pack_valid,
  input  logic                     pack_ready,
  output logic [WORDS*FIELD_W-1:0] pack_bits,
  output logic [$clog2(WORDS*FIELD_W+1)-1:0] pack_size,
  output logic                     pack_done,
  input  logic                     unpk_valid,
  output logic                     unpk_ready,
  input  logic [WORDS*FIELD_W-1:0] unpk_bits,
  output logic                     rebuilt_valid,
  input  logic                     rebuilt_ready,
  output logic [WORDS*WORD_W-1:0]  rebuilt_line
);
  fpc_line_pack #(.WORDS(WORDS)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (line_valid),
    .in_ready  (line_ready),
    .in_line   (line_data),
    .out_valid (pack_valid),
    .out_ready (pack_ready),
    .out_bits  (pack_bits),
    .out_size  (pack_size),
    .out_done  (pack_done)
  );

  fpc_line_unpack #(.WORDS(WORDS)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (unpk_valid),
    .in_ready  (unpk_ready),
    .in_bits   (unpk_bits),
    .out_valid (rebuilt_valid),
    .out_ready (rebuilt_ready),
    .out_line  (rebuilt_line)
  );
endmodule

// File: tb/test_fpc_line_codec.sv
`timescale 1ns/1ps
module test_fpc_line_codec;
  localparam int WORDS    = 16;
  localparam int LINE_W   = WORDS * 32;
  localparam int MAX_BITS = WORDS * 35;
  localparam int SIZE_W   = $clog2(MAX_BITS + 1);

  typedef struct packed {
    logic [31:0] w;
    logic [2:0]  p;
    logic        tie;
  } ent_t;

  localparam ent_t TAB [16] = '{
    '{32'h00000000, 3'b000, 1'b0},
    '{32'h00000007, 3'b001, 1'b0},
    '{32'hFFFFFFF8, 3'b001, 1'b0},
    '{32'h0000007F, 3'b010, 1'b0},
    '{32'hFFFFFF80, 3'b010, 1'b0},
    '{32'h12121212, 3'b110, 1'b0},
    '{32'h00007FFF, 3'b011, 1'b0},
    '{32'hFFFF8000, 3'b011, 1'b0},
    '{32'hABCD0000, 3'b100, 1'b0},
    '{32'h007F0012, 3'b101, 1'b0},
    '{32'hFF80FFFF, 3'b101, 1'b0},
    '{32'hFFFFFFFF, 3'b001, 1'b1},
    '{32'h80808080, 3'b110, 1'b0},
    '{32'h12345678, 3'b111, 1'b0},
    '{32'h00010000, 3'b100, 1'b1},
    '{32'h00800080, 3'b111, 1'b0}
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                line_valid = 1'b0;
  logic                line_ready;
  logic [LINE_W-1:0]   line_data = '0;
  logic                pack_valid;
  logic                pack_ready = 1'b0;
  logic [MAX_BITS-1:0] pack_bits;
  logic [SIZE_W-1:0]   pack_size;
  logic                pack_done;
  logic                unpk_valid = 1'b0;
  logic                unpk_ready;
  logic [MAX_BITS-1:0] unpk_bits = '0;
  logic                rebuilt_valid;
  logic                rebuilt_ready = 1'b0;
  logic [LINE_W-1:0]   rebuilt_line;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  fpc_line_codec #(.WORDS(WORDS)) i_fpc_line_codec (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [575:0] act, input logic [575:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int plen(logic [2:0] p);
    case (p)
      3'b000: return 0;
      3'b001: return 4;
      3'b010, 3'b110: return 8;
      3'b011, 3'b100, 3'b101: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] ppay(logic [31:0] w, logic [2:0] p);
    case (p)
      3'b000: return 32'd0;
      3'b001: return {28'd0, w[3:0]};
      3'b010, 3'b110: return {24'd0, w[7:0]};
      3'b011: return {16'd0, w[15:0]};
      3'b100: return {16'd0, w[31:16]};
      3'b101: return {16'd0, w[23:16], w[7:0]};
      default: return w;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] p, logic tie);
    if (tie) return "R8";
    case (p)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_line(input logic [LINE_W-1:0] ln,
                          input logic [3*WORDS-1:0] pf,
                          input logic [WORDS-1:0] tie);
    logic [MAX_BITS-1:0] eb;
    int pos;
    int offs [WORDS];
    bit early;
    eb = '0;
    pos = 0;
    for (int i = 0; i < WORDS; i++) begin
      logic [2:0]  p;
      logic [31:0] pl;
      p = pf[3*i +: 3];
      pl = ppay(ln[32*i +: 32], p);
      offs[i] = pos;
      for (int b = 2; b >= 0; b--) begin eb[MAX_BITS-1-pos] = p[b]; pos++; end
      for (int b = plen(p) - 1; b >= 0; b--) begin eb[MAX_BITS-1-pos] = pl[b]; pos++; end
    end

    @(negedge clk);
    line_data  = ln;
    line_valid = 1'b1;
    @(negedge clk);
    line_valid = 1'b0;
    early = 0;
    for (int c = 1; c <= 16; c++) begin
      @(negedge clk);
      if (c < 16 && (pack_done || pack_valid)) early = 1;
    end
    chk(!early && pack_done && pack_valid, "R11", "done/valid at edge 16",
        {early, pack_done, pack_valid}, 3'b011);
    chk(pack_bits == eb, "R9", "packed stream", pack_bits, eb);
    chk(pack_size == SIZE_W'(pos), "R10", "size", pack_size, pos);
    for (int i = 0; i < WORDS; i++) begin
      logic [2:0] ap;
      for (int b = 0; b < 3; b++) ap[2-b] = pack_bits[MAX_BITS-1-offs[i]-b];
      chk(ap == pf[3*i +: 3], req_of(pf[3*i +: 3], tie[i]), "word code",
          ap, pf[3*i +: 3]);
    end
    @(negedge clk);
    chk(!pack_done && pack_valid, "R11", "done drops after one cycle",
        {pack_done, pack_valid}, 2'b01);

    unpk_bits  = pack_bits;
    unpk_valid = 1'b1;
    line_valid = 1'b1;          // offered while packer is busy: ignored
    line_data  = ~ln;
    @(negedge clk);
    unpk_valid = 1'b0;
    early = 0;
    for (int c = 1; c <= 16; c++) begin
      @(negedge clk);
      if (c < 16 && rebuilt_valid) early = 1;
    end
    chk(!early && rebuilt_valid, "R12", "rebuilt valid at edge 16",
        {early, rebuilt_valid}, 2'b01);
    chk(rebuilt_line == ln, "R12", "round trip", rebuilt_line, ln);
    chk(pack_valid && !line_ready && pack_bits == eb, "R11", "held under back-pressure",
        pack_bits, eb);
    line_valid    = 1'b0;
    pack_ready    = 1'b1;
    rebuilt_ready = 1'b1;
    @(negedge clk);
    pack_ready    = 1'b0;
    rebuilt_ready = 1'b0;
    chk(!pack_valid && line_ready && !rebuilt_valid && unpk_ready, "R11",
        "release returns to idle", {pack_valid, line_ready, rebuilt_valid, unpk_ready}, 4'b0101);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [LINE_W-1:0]  ln;
    logic [3*WORDS-1:0] pf;
    logic [WORDS-1:0]   tie;

    repeat (3) @(negedge clk);
    chk(line_ready && !pack_valid && !pack_done && unpk_ready && !rebuilt_valid,
        "R11", "reset state",
        {line_ready, pack_valid, pack_done, unpk_ready, rebuilt_valid}, 5'b10010);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: each line rotates through the pattern table
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < WORDS; i++) begin
        ent_t e;
        e = TAB[(i + 5*k) % 16];
        ln[32*i +: 32] = e.w;
        pf[3*i +: 3]   = e.p;
        tie[i]         = e.tie;
      end
      run_line(ln, pf, tie);
    end

    // R1 corner: all-zero line packs to codes only, 48 bits
    run_line('0, '0, '0);

    // R7 corner: incompressible line fills the full 560 bits
    for (int i = 0; i < WORDS; i++) begin
      ln[32*i +: 32] = 32'h12345678 + 32'(i) * 32'h01010101;
      pf[3*i +: 3]   = 3'b111;
    end
    run_line(ln, pf, '0);

    // R8 corner: every word ties between patterns
    for (int i = 0; i < WORDS; i++) begin
      ln[32*i +: 32] = (i % 2 == 0) ? 32'hFFFFFFFF : 32'h00010000;
      pf[3*i +: 3]   = (i % 2 == 0) ? 3'b001 : 3'b100;
    end
    run_line(ln, pf, '1);

    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule